// File: doc/BRIEF.md
# Edge/Level Interrupt Pending Controller

This block gathers sixty-four device interrupt lines and turns them into requests on eight parent interrupt outputs. Each line can work in one of two modes. In level mode, the line's request copies the input. In edge mode, a low-to-high transition latches a request. That request survives the input falling again and lasts until software clears it. A per-line routing entry names the parent output that the line drives. A per-line mask keeps a line from being taken into service, but it does not stop the request from being recorded.

The block keeps four pieces of state for each line: the level sampled on the previous clock, a pending flag, an in-service flag and the configuration. On every clock, each unmasked pending line that is not yet in service is taken into service. A parent output is high while at least one in-service line is routed to it. A small service state machine has two states, `ST_IDLE` and `ST_RETIRE`, and it releases lines that are in service but no longer pending.
- Transition `IDLE->RETIRE`: taken when at least one such candidate exists.
- `ST_RETIRE` hold: the machine stays in `ST_RETIRE` while candidates remain. It releases the lowest-numbered candidate on each clock.
- Transition `RETIRE->IDLE`: taken once no candidates are left.

A single write port carries all configuration. Select code 0 loads the 64-bit mode word, where 1 means edge mode. Code 1 loads the mask word. Code 2 is a write-one-to-clear of pending flags. Code 3 loads the routing entry of the line given by the index field from data bits [2:0].

Top module: `irq_pending_ctrl`

## Requirements
- R1: After reset, all parent outputs are low and every line is in level mode, unmasked and routed to output 0.
- R2: In edge mode (mode bit 1), a high input whose previously sampled level was low sets the pending flag on the next clock.
- R3: In edge mode, a falling input leaves the pending flag set, and the routed parent output stays high.
- R4: In level mode (mode bit 0), the pending flag takes the input value sampled on each clock, so the parent output follows a level line in both directions.
- R5: An unmasked pending line that is not in service enters service on the next clock. A line that is in service and still pending never leaves service.
- R6: In `ST_RETIRE`, exactly one candidate leaves service per clock, and it is the lowest-numbered one.
- R7: A line whose mask bit is 1 never enters service. Its request is still recorded, so clearing the mask later raises the output.
- R8: Writing select code 2 with data bit i set clears line i's pending flag on the next clock. This applies unless the same clock sees a new rising edge on that line, in which case the edge wins. The output is then released through the service state machine.
- R9: A line drives the parent output whose number equals its 3-bit routing entry (select code 3, index = line, data[2:0] = output).
- R10: The machine moves from `ST_IDLE` to `ST_RETIRE` exactly when candidates exist, and returns when none do. No line leaves service while the machine is in `ST_IDLE`.
- R11: In edge mode, once a falling input has been sampled, the next rising input latches a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Device interrupt lines, one bit per line |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 mask, 2 clear, 3 routing |
| wr_idx | input | 6 | Line number for a routing write |
| wr_data | input | 64 | Write data |
| parent_irq | output | 8 | Parent interrupt outputs |

## Verification
A raised input or a removed mask shows on a parent output two clocks after it is applied: one clock latches the pending flag and one takes the line into service. A level line that drops, or an edge line whose request is cleared, releases its output three clocks later: pending clears, then the machine enters `ST_RETIRE`, then the line is retired. Each further line with a dropped request retires one clock later than the one before it. The bench drives inputs on falling edges and updates a behavioural model on rising edges. It compares all eight outputs on every falling edge, and the directed checks sample the exact clock at which each of these delays ends.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DEF_NUM_SRC = 64;
    localparam int DEF_NUM_OUT = 8;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_VECTOR = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RETIRE = 1'b1
    } svc_state_e;

endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int NUM_OUT = DEF_NUM_OUT,
    localparam int VEC_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  reg_sel_e                 wr_sel,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [NUM_SRC-1:0]       wr_data,
    output logic [NUM_SRC-1:0]       mode_q,
    output logic [NUM_SRC-1:0]       mask_q,
    output logic [NUM_SRC*VEC_W-1:0] vec_flat,
    output logic [NUM_SRC-1:0]       clr_hit
);

    logic mode_we;
    logic mask_we;
    logic vec_we;

    always_comb begin
        mode_we = wr_en && (wr_sel == SEL_MODE);
        mask_we = wr_en && (wr_sel == SEL_MASK);
        vec_we  = wr_en && (wr_sel == SEL_VECTOR);
        clr_hit = (wr_en && (wr_sel == SEL_CLEAR)) ? wr_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '0;
        end else begin
            if (mode_we) mode_q <= wr_data;
            if (mask_we) mask_q <= wr_data;
        end
    end

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_vec
        logic [VEC_W-1:0] vec_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vec_q <= '0;
            end else if (vec_we && (wr_idx == IDX_W'(gi))) begin
                vec_q <= wr_data[VEC_W-1:0];
            end
        end
        assign vec_flat[gi*VEC_W +: VEC_W] = vec_q;
    end

endmodule

// File: rtl/irqc_pend_unit.sv
module irqc_pend_unit
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] mode_q,
    input  logic [NUM_SRC-1:0] clr_hit,
    output logic [NUM_SRC-1:0] pend_q
);

    logic [NUM_SRC-1:0] last_q;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        logic rise;
        logic pend_d;

        always_comb begin
            rise = irq_in[gi] && !last_q[gi];
            if (!mode_q[gi]) begin
                pend_d = irq_in[gi];
            end else if (rise) begin
                pend_d = 1'b1;
            end else if (clr_hit[gi]) begin
                pend_d = 1'b0;
            end else begin
                pend_d = pend_q[gi];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                last_q[gi] <= 1'b0;
                pend_q[gi] <= 1'b0;
            end else begin
                last_q[gi] <= irq_in[gi];
                pend_q[gi] <= pend_d;
            end
        end

        // R3: an edge request only goes away through the clear register
        p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[gi] && pend_q[gi] && !clr_hit[gi]) |=> pend_q[gi])
            else $error("edge request lost on source %0d", gi);

        // R4: level sources copy the sampled input
        p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_q[gi] |=> (pend_q[gi] == $past(irq_in[gi])))
            else $error("level pending mismatch on source %0d", gi);
    end

endmodule

// File: rtl/irqc_service_fsm.sv
module irqc_service_fsm
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_q,
    input  logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] svc_q
);

    svc_state_e         state_q;
    svc_state_e         state_d;
    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] take;
    logic [NUM_SRC-1:0] retire_oh;
    logic [NUM_SRC-1:0] svc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            svc_q   <= '0;
        end else begin
            state_q <= state_d;
            svc_q   <= svc_d;
        end
    end

    always_comb begin
        cand      = svc_q & ~pend_q;
        take      = pend_q & ~mask_q & ~svc_q;
        retire_oh = '0;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (|cand) state_d = ST_RETIRE;
            end
            ST_RETIRE: begin
                if (|cand) begin
                    retire_oh = cand & (~cand + 1'b1);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        svc_d = (svc_q | take) & ~retire_oh;
    end

    // R6: at most one line leaves service per clock
    p_single_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETIRE) |=> ($countones($past(svc_q) & ~svc_q) <= 1))
        else $error("more than one line retired in a clock");

    // R10: nothing leaves service in the idle state
    p_idle_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (($past(svc_q) & ~svc_q) == '0))
        else $error("line retired while idle");

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chk
        // R7: masked lines never enter service
        p_mask_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[gi] && !svc_q[gi]) |=> !svc_q[gi])
            else $error("masked source %0d entered service", gi);

        // R5: a pending line in service stays in service
        p_pend_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[gi] && svc_q[gi]) |=> svc_q[gi])
            else $error("pending source %0d left service", gi);
    end

endmodule

// File: rtl/irqc_route.sv
module irqc_route
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int NUM_OUT = DEF_NUM_OUT,
    localparam int VEC_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic [NUM_SRC-1:0]       svc_q,
    input  logic [NUM_SRC*VEC_W-1:0] vec_flat,
    output logic [NUM_OUT-1:0]       parent_irq
);

    for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
        logic [NUM_SRC-1:0] hit;
        always_comb begin
            for (int i = 0; i < NUM_SRC; i++) begin
                hit[i] = svc_q[i] && (vec_flat[i*VEC_W +: VEC_W] == VEC_W'(go));
            end
        end
        assign parent_irq[go] = |hit;
    end

endmodule

// File: rtl/irq_pending_ctrl.sv
module irq_pending_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int NUM_OUT = DEF_NUM_OUT,
    localparam int VEC_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_OUT-1:0] parent_irq
);

    reg_sel_e                 sel;
    logic [NUM_SRC-1:0]       mode_q;
    logic [NUM_SRC-1:0]       mask_q;
    logic [NUM_SRC*VEC_W-1:0] vec_flat;
    logic [NUM_SRC-1:0]       clr_hit;
    logic [NUM_SRC-1:0]       pend_q;
    logic [NUM_SRC-1:0]       svc_q;

    assign sel = reg_sel_e'(wr_sel);

    irqc_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (sel),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .mode_q   (mode_q),
        .mask_q   (mask_q),
        .vec_flat (vec_flat),
        .clr_hit  (clr_hit)
    );

    irqc_pend_unit #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .mode_q  (mode_q),
        .clr_hit (clr_hit),
        .pend_q  (pend_q)
    );

    irqc_service_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_q (pend_q),
        .mask_q (mask_q),
        .svc_q  (svc_q)
    );

    irqc_route #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_route (
        .svc_q      (svc_q),
        .vec_flat   (vec_flat),
        .parent_irq (parent_irq)
    );

    // R1: outputs are quiet in the first clock after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (parent_irq == '0))
        else $error("parent output high out of reset");

endmodule

// File: tb/irq_pending_ctrl_test.sv
`timescale 1ns/1ps
module irq_pending_ctrl_test;

    localparam int NS = 64;
    localparam int NO = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [5:0]    wr_idx = '0;
    logic [NS-1:0] wr_data = '0;
    logic [NO-1:0] parent_irq;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    irq_pending_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .parent_irq (parent_irq)
    );

    // behavioural reference model
    bit m_mode [NS];
    bit m_mask [NS];
    bit m_last [NS];
    bit m_pend [NS];
    bit m_svc  [NS];
    int m_vec  [NS];
    bit m_retire_state;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_mode[i] = 0; m_mask[i] = 0; m_last[i] = 0;
                m_pend[i] = 0; m_svc[i] = 0; m_vec[i] = 0;
            end
            m_retire_state = 0;
        end else begin
            int first;
            bit any;
            bit n_svc [NS];
            first = -1;
            any = 0;
            for (int i = 0; i < NS; i++) begin
                if (m_svc[i] && !m_pend[i]) begin
                    any = 1;
                    if (first < 0) first = i;
                end
            end
            for (int i = 0; i < NS; i++) begin
                n_svc[i] = m_svc[i] || (m_pend[i] && !m_mask[i]);
                if (m_retire_state && i == first) n_svc[i] = 0;
            end
            m_retire_state = any;
            for (int i = 0; i < NS; i++) begin
                if (!m_mode[i]) m_pend[i] = irq_in[i];
                else if (irq_in[i] && !m_last[i]) m_pend[i] = 1;
                else if (wr_en && wr_sel == 2'd2 && wr_data[i]) m_pend[i] = 0;
                m_last[i] = irq_in[i];
                m_svc[i] = n_svc[i];
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: for (int i = 0; i < NS; i++) m_mode[i] = wr_data[i];
                    2'd1: for (int i = 0; i < NS; i++) m_mask[i] = wr_data[i];
                    2'd3: m_vec[wr_idx] = int'(wr_data[2:0]);
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [NO-1:0] model_out();
        logic [NO-1:0] r = '0;
        for (int i = 0; i < NS; i++) if (m_svc[i]) r[m_vec[i]] = 1'b1;
        return r;
    endfunction

    task automatic step();
        @(negedge clk);
        checks++;
        if (parent_irq !== model_out()) begin
            errors++;
            $display("FAIL %s model compare: actual=%b expected=%b", cur_req, parent_irq, model_out());
        end
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic expect_out(input logic [NO-1:0] exp, input string req);
        checks++;
        if (parent_irq !== exp) begin
            errors++;
            $display("FAIL %s directed: actual=%b expected=%b", req, parent_irq, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [5:0] idx, input logic [NS-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_idx = idx; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        steps(3);
        expect_out(8'h00, "R1");
        irq_in[0] = 1'b1;
        steps(2);
        expect_out(8'h01, "R1 default route to output 0");
        irq_in[0] = 1'b0;
        steps(4);

        // R9 / R4 / R5 / R10: level line routed to output 3
        cur_req = "R9";
        wr(2'd3, 6'd5, 64'd3);
        irq_in[5] = 1'b1;
        step();
        expect_out(8'h00, "R5 not yet in service");
        step();
        expect_out(8'h08, "R9 routed to output 3");
        cur_req = "R10";
        irq_in[5] = 1'b0;
        steps(2);
        expect_out(8'h08, "R10 still held before retire");
        step();
        expect_out(8'h00, "R4 level release");
        steps(2);

        // R2 / R3 / R8 / R11: edge line 10 routed to output 6
        cur_req = "R2";
        wr(2'd3, 6'd10, 64'd6);
        wr(2'd0, 6'd0, 64'd1 << 10);
        irq_in[10] = 1'b1;
        steps(2);
        expect_out(8'h40, "R2 edge raises output 6");
        cur_req = "R3";
        irq_in[10] = 1'b0;
        steps(6);
        expect_out(8'h40, "R3 edge request kept after fall");
        cur_req = "R8";
        wr(2'd2, 6'd0, 64'd1 << 10);
        step();
        expect_out(8'h40, "R8 two clocks after clear");
        step();
        expect_out(8'h00, "R8 released after clear");
        steps(2);
        cur_req = "R11";
        irq_in[10] = 1'b1;
        steps(2);
        expect_out(8'h40, "R11 re-armed edge");
        irq_in[10] = 1'b0;
        wr(2'd2, 6'd0, 64'd1 << 10);
        steps(4);
        expect_out(8'h00, "R8 second clear");

        // R7: mask blocks service, request still recorded
        cur_req = "R7";
        wr(2'd1, 6'd0, 64'd1 << 20);
        irq_in[20] = 1'b1;
        steps(5);
        expect_out(8'h00, "R7 masked line blocked");
        wr(2'd1, 6'd0, 64'd0);
        step();
        expect_out(8'h01, "R7 unmask raises output 0");
        irq_in[20] = 1'b0;
        steps(4);

        // R6: lowest-numbered candidate retires first
        cur_req = "R6";
        wr(2'd3, 6'd30, 64'd1);
        wr(2'd3, 6'd31, 64'd2);
        irq_in[30] = 1'b1;
        irq_in[31] = 1'b1;
        steps(3);
        expect_out(8'h06, "R6 both raised");
        irq_in[30] = 1'b0;
        irq_in[31] = 1'b0;
        steps(3);
        expect_out(8'h04, "R6 line 30 retired first");
        step();
        expect_out(8'h00, "R6 line 31 retired next");
        steps(2);

        // mixed traffic against the model
        cur_req = "R5";
        for (int c = 0; c < 2000; c++) begin
            if (($urandom % 4) == 0) irq_in[$urandom % NS] ^= 1'b1;
            if (($urandom % 8) == 0) begin
                wr_en = 1'b1;
                wr_sel = 2'($urandom % 4);
                wr_idx = 6'($urandom % NS);
                wr_data = {$urandom, $urandom};
            end else begin
                wr_en = 1'b0;
            end
            step();
        end
        wr_en = 1'b0;
        steps(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule